// File: doc/BRIEF.md
# Stability-Filtered Bus Synchronizer

This block brings a multi-bit value, typically a free-running counter or a status word, from a source clock domain into a destination clock domain that has no phase or frequency relation to it. On every destination clock edge the source bus is captured into a two-stage chain of ordinary flip-flops. The newest capture sits in stage 0 and the capture before it sits in stage 1.

The output register is not simply the last chain stage. It loads the stage 1 word only when stage 0 and stage 1 hold the same value. In that case two consecutive captures agreed. A capture taken while the source bits were mid-transition, with some bits old and some new, is very unlikely to be repeated on the next edge, so it never reaches the output. When the source changes on every destination edge, the output keeps its last good word.

Top module: `stable_bus_sync`

## Requirements
- R1: While `rst_ni` is low, `dst_bus_o` is zero. Both chain stages also clear to zero, so the output stays zero after release until the bus has been stable.
- R2: On each rising `clk_i` edge, stage 0 captures `src_bus_i` and stage 1 takes the previous stage 0 word.
- R3: On a `clk_i` edge where stage 0 equals stage 1, `dst_bus_o` takes the stage 1 word.
- R4: On a `clk_i` edge where stage 0 differs from stage 1, `dst_bus_o` keeps its value.
- R5: A value present on `src_bus_i` at three consecutive rising edges is on `dst_bus_o` after the third of those edges.
- R6: If `src_bus_i` shows a different value at every rising edge, `dst_bus_o` does not change.
- R7: `dst_bus_o` changes only on an edge that follows two consecutive agreeing captures. It only ever holds zero or a word the source presented at two consecutive edges.
- R8: The bus width is the parameter `WIDTH`, default 32, and all bits, including the most significant one, pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Destination clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_bus_i | input | WIDTH | Word from the source domain |
| dst_bus_o | output | WIDTH | Filtered word in the destination domain |

## Verification
The assertions assume that each capture of `src_bus_i` returns a settled word. In silicon, a sample taken during a source change can return any mix of old and new bits, and a metastable stage can resolve either way. The properties do not model this. They only relate the registered chain and the output across edges. The stimulus keeps within that assumption by changing the source bus only on falling destination edges, far from the capturing edge. The bench mixes held values, values held for exactly two edges, values that change every edge, and full-width patterns.

// File: rtl/bsync_pkg.sv
package bsync_pkg;
  localparam int unsigned BSYNC_DEF_WIDTH = 32;
  localparam int unsigned BSYNC_STAGES    = 2;
endpackage

// File: rtl/bsync_chain.sv
module bsync_chain #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [W-1:0]              d_i,
  output logic [DEPTH-1:0][W-1:0]   stg_o
);
  // each stage is a plain register so it acts as a synchronizer flop
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [W-1:0] q;
    logic [W-1:0] nxt;
    if (g == 0) begin : g_head
      assign nxt = d_i;
    end else begin : g_tail
      assign nxt = stg_o[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= nxt;
    end
    assign stg_o[g] = q;
  end
endmodule

// File: rtl/bsync_hold.sv
module bsync_hold #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] newer_i,
  input  logic [W-1:0] older_i,
  output logic [W-1:0] q_o
);
  logic agree;
  assign agree = (newer_i == older_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (agree) q_o <= older_i;
  end
endmodule

// File: rtl/stable_bus_sync.sv
module stable_bus_sync #(
  parameter int unsigned WIDTH = bsync_pkg::BSYNC_DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] src_bus_i,
  output logic [WIDTH-1:0] dst_bus_o
);
  localparam int unsigned NSTG = bsync_pkg::BSYNC_STAGES;

  logic [NSTG-1:0][WIDTH-1:0] stg_q;

  bsync_chain #(.W(WIDTH), .DEPTH(NSTG)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (src_bus_i),
    .stg_o  (stg_q)
  );

  bsync_hold #(.W(WIDTH)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .newer_i (stg_q[0]),
    .older_i (stg_q[1]),
    .q_o     (dst_bus_o)
  );
endmodule

// File: rtl/bsync_checker.sv
module bsync_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] src_i,
  input logic [W-1:0] s0_i,
  input logic [W-1:0] s1_i,
  input logic [W-1:0] out_i
);
  AST_ZERO_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni) !$past(rst_ni) |-> out_i == '0); // R1
  AST_CHAIN_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni) $past(rst_ni) |-> s1_i == $past(s0_i) && s0_i == $past(src_i)); // R2
  AST_LOAD_ON_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni) (s0_i == s1_i) |=> out_i == $past(s1_i)); // R3
  AST_HOLD_ON_DIFFER: assert property (@(posedge clk_i) disable iff (!rst_ni) (s0_i != s1_i) |=> $stable(out_i)); // R4
  AST_CHANGE_NEEDS_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni) (out_i != $past(out_i)) |-> $past(s0_i) == $past(s1_i)); // R7
endmodule

bind stable_bus_sync bsync_checker #(.W(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .src_i  (src_bus_i),
  .s0_i   (stg_q[0]),
  .s1_i   (stg_q[1]),
  .out_i  (dst_bus_o)
);

// File: tb/sim_stable_bus_sync.sv
module sim_stable_bus_sync;
  localparam int unsigned W = 32;
  localparam time CLK_PERIOD = 10ns;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] src_bus_i = '0;
  logic [W-1:0] dst_bus_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [W-1:0] hist[$];
  logic [W-1:0] exp_out = '0;
  bit           pair_ok[logic [W-1:0]];
  logic [W-1:0] last_smp = '0;
  bit           live = 1'b0;

  stable_bus_sync #(.WIDTH(W)) u0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_bus_i (src_bus_i),
    .dst_bus_o (dst_bus_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: last two captures held in a queue
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = '{'0, '0};
      exp_out = '0;
      live = 1'b0;
    end else begin
      if (hist[0] == hist[1]) begin
        exp_out = hist[1];
        pair_ok[hist[1]] = 1'b1;
      end
      hist.push_front(src_bus_i);
      void'(hist.pop_back());
      last_smp = src_bus_i;
      live = 1'b1;
    end
  end

  // per-cycle comparison (R3/R4) and provenance (R7)
  always @(negedge clk_i) begin
    if (live && !done) begin
      chk("R3/R4 cycle model", dst_bus_o, exp_out);
      n_chk++;
      if (dst_bus_o != '0 && !pair_ok.exists(dst_bus_o)) begin
        n_err++;
        $display("FAIL R7: actual=%h expected=a value presented twice", dst_bus_o);
      end
    end
  end

  task automatic drive(input logic [W-1:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      src_bus_i = v;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] held;
    src_bus_i = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk_i);
    chk("R1 in reset", dst_bus_o, '0);
    rst_ni = 1'b1;
    // bus was DEADBEEF before release; chain cleared, so out still zero one edge later
    @(negedge clk_i);
    chk("R1 after release", dst_bus_o, '0);
    src_bus_i = 32'h0000_0000;
    @(negedge clk_i);
    src_bus_i = 32'h1234_5678;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R5 not yet after two edges", dst_bus_o, '0);
    @(negedge clk_i);
    chk("R5 stable value after third edge", dst_bus_o, 32'h1234_5678);

    // R6: a different value at every edge leaves output frozen
    held = dst_bus_o;
    for (int i = 1; i <= 40; i++) begin
      src_bus_i = 32'hA000_0000 + i;
      @(negedge clk_i);
      chk("R6 fast source holds output", dst_bus_o, held);
    end

    // R8 full width, MSB set
    drive(32'hFFFF_FFFF, 1);
    repeat (3) @(negedge clk_i);
    chk("R8 all ones", dst_bus_o, 32'hFFFF_FFFF);
    drive(32'h8000_0001, 1);
    repeat (3) @(negedge clk_i);
    chk("R8 msb and lsb", dst_bus_o, 32'h8000_0001);

    // R2/R3 value held for exactly two edges: loaded on the following edge
    src_bus_i = 32'h0BAD_F00D;
    @(negedge clk_i);
    @(negedge clk_i);
    src_bus_i = 32'h5555_0000;
    @(negedge clk_i);
    chk("R2/R3 two-edge value loaded", dst_bus_o, 32'h0BAD_F00D);
    src_bus_i = 32'h6666_0000;
    @(negedge clk_i);
    chk("R4 single-edge value ignored", dst_bus_o, 32'h0BAD_F00D);

    // counter that advances every third edge
    for (int i = 0; i < 60; i++) begin
      src_bus_i = 32'h0001_0000 + (i / 3);
      @(negedge clk_i);
    end
    // pseudo-random mix of hold lengths
    for (int i = 0; i < 300; i++) begin
      int len;
      len = 1 + ((i * 7) % 4);
      drive(32'h9E37_79B9 * (i + 1), len);
    end
    repeat (4) @(negedge clk_i);
    chk("R5 final settle", dst_bus_o, src_bus_i);

    // reset mid-run clears output
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset clears", dst_bus_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R5 after re-reset", dst_bus_o, src_bus_i);
    finish_run();
  end
endmodule